// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block collects thirteen level-sensitive interrupt sources, numbered 1 to 13, and hands the processor one interrupt request at a time. Each request is a 3-bit level and an 8-bit vector.

A source takes part in arbitration when its input is high and its mask bit is clear. Among those sources, the one whose 5-bit priority code (control bits 4:0) is largest wins. Equal codes resolve to the lower-numbered source. The upper three bits of the code form the level.

The vector is chosen per source. It is either an autovector computed from the level, or a software-programmed value. Only three sources own a vector register: source 8 (watchdog), source 12 (first serial port) and source 13 (second serial port). Every other source that does not use the autovector gets a fixed fallback vector.

Software reaches the control, mask, pending and vector registers through a simple byte-addressed register port. Writes take effect on the clock edge. Read data is combinational. The level and vector outputs are registered.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset:
  - the mask reads 0x3FFE, with every source masked;
  - the control registers of sources 1 to 7 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C;
  - source 8 reads 0x1C, sources 9 to 11 read 0x80, and sources 12 and 13 read 0x00;
  - the three vector registers read 0x0F;
  - the level and vector outputs are 0.
- R2: The pending register at offset 0x3A shows the live source inputs. Bit n is source n, and bits 0, 14 and 15 read 0. Writes to offset 0x3A change nothing.
- R3: A source is active only when its input is 1 and its mask bit is 0. The mask at offset 0x36 keeps bits 13:1 of a write; bit n masks source n, and the other bits read 0.
- R4: Among the active sources, the one with the numerically largest control bits 4:0 wins.
- R5: When two active sources have equal control bits 4:0, the lower-numbered source wins.
- R6: When no source is active, or the winner's bits 4:0 are below 4, both the level and vector outputs are 0.
- R7: The output level equals control bits 4:2 of the winning source.
- R8: When control bit 7 of the winner is 1, the vector is 24 plus the level.
- R9: When control bit 7 of the winner is 0, the vector comes from a per-source register or a fixed value:
  - source 8 uses the watchdog vector register (offset 0x42);
  - source 12 uses the first serial vector register (offset 0x70);
  - source 13 uses the second serial vector register (offset 0x71);
  - any other source gives 0x0F.
- R10: The control register of source n sits at offset 0x13+n and reads back all 8 bits in rd_data[7:0]. Vector registers read back all 8 bits. Unmapped offsets read 0.
- R11: The level and vector outputs change exactly one clock edge after any change to the source inputs or to a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 13 | Source levels; bit n-1 is source n |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_wr_data | input | 16 | Write data; control and vector registers use bits 7:0 |
| bus_rd_data | output | 16 | Combinational read data for bus_addr |
| irq_level | output | 3 | Registered interrupt level, 0 when idle |
| irq_vector | output | 8 | Registered interrupt vector, 0 when idle |

## Verification
The bench aims at the following corner cases, each compared cycle by cycle against a behavioural reference:
- **Equal priority codes.** Two sources with the same code run together. An arbiter that replaced on greater-or-equal would present the higher-numbered source.
- **Codes 1 to 3.** Active sources with these codes must raise nothing. A design that tested for a non-zero code instead of the threshold would raise a level-0 request with a vector.
- **Autovector versus dedicated vectors.** Control bit 7 is toggled, and sources that own no vector register are used. A wrong select would surface a stale register value instead of 24+level or 0x0F.
- **Register side effects.** Writes to the pending register and to mask bits 0, 14 and 15 are applied. A randomized phase mixes source changes with control and mask writes, so any extra or missing cycle of output latency shows as a mismatch.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;

    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned REG_DATA_W = 16;
    localparam int unsigned SRC_IDX_W  = 4;   // indexes up to 15 sources

    // register offsets
    localparam logic [REG_ADDR_W-1:0] A_CTRL_BASE = 8'h14;
    localparam logic [REG_ADDR_W-1:0] A_MASK      = 8'h36;
    localparam logic [REG_ADDR_W-1:0] A_PEND      = 8'h3A;
    localparam logic [REG_ADDR_W-1:0] A_VEC_WDOG  = 8'h42;
    localparam logic [REG_ADDR_W-1:0] A_VEC_SERA  = 8'h70;
    localparam logic [REG_ADDR_W-1:0] A_VEC_SERB  = 8'h71;

    localparam logic [7:0] FALLBACK_VEC  = 8'h0F;
    localparam logic [7:0] AUTOVEC_BASE  = 8'd24;
    localparam logic [7:0] VEC_RESET     = 8'h0F;
    localparam logic [4:0] PRESENT_FLOOR = 5'd4;

    typedef struct packed {
        logic [2:0] level;
        logic [7:0] vector;
    } irq_out_t;

    function automatic logic [7:0] ctrl_reset_value(input int unsigned src);
        if (src >= 1 && src <= 7)       return 8'(src * 4);
        else if (src == 8)              return 8'h1C;
        else if (src >= 9 && src <= 11) return 8'h80;
        else                            return 8'h00;
    endfunction

endpackage

// File: rtl/prio_vec_intc_regs.sv
module prio_vec_intc_regs
    import prio_vec_intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_ADDR_W-1:0]        addr,
    input  logic [REG_DATA_W-1:0]        wr_data,
    input  logic [NUM_SRC-1:0]           src_req,
    output logic [REG_DATA_W-1:0]        rd_data,
    output logic [NUM_SRC:1][7:0]        ctrl_q,
    output logic [NUM_SRC:1]             mask_q,
    output logic [NUM_SRC:1]             pend,
    output logic [7:0]                   vec_wdog_q,
    output logic [7:0]                   vec_sera_q,
    output logic [7:0]                   vec_serb_q
);

    assign pend = src_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 1; n <= int'(NUM_SRC); n++) begin
                ctrl_q[n] <= ctrl_reset_value(n);
            end
            mask_q     <= '1;
            vec_wdog_q <= VEC_RESET;
            vec_sera_q <= VEC_RESET;
            vec_serb_q <= VEC_RESET;
        end else if (wr_en) begin
            for (int n = 1; n <= int'(NUM_SRC); n++) begin
                if (addr == A_CTRL_BASE + 8'(n - 1)) begin
                    ctrl_q[n] <= wr_data[7:0];
                end
            end
            if (addr == A_MASK)     mask_q     <= wr_data[NUM_SRC:1];
            if (addr == A_VEC_WDOG) vec_wdog_q <= wr_data[7:0];
            if (addr == A_VEC_SERA) vec_sera_q <= wr_data[7:0];
            if (addr == A_VEC_SERB) vec_serb_q <= wr_data[7:0];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int n = 1; n <= int'(NUM_SRC); n++) begin
            if (addr == A_CTRL_BASE + 8'(n - 1)) begin
                rd_data = {8'h00, ctrl_q[n]};
            end
        end
        unique case (addr)
            A_MASK:     rd_data = REG_DATA_W'({mask_q, 1'b0});
            A_PEND:     rd_data = REG_DATA_W'({pend, 1'b0});
            A_VEC_WDOG: rd_data = {8'h00, vec_wdog_q};
            A_VEC_SERA: rd_data = {8'h00, vec_sera_q};
            A_VEC_SERB: rd_data = {8'h00, vec_serb_q};
            default:    ;
        endcase
    end

endmodule

// File: rtl/prio_vec_intc_arb.sv
module prio_vec_intc_arb
    import prio_vec_intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13
) (
    input  logic [NUM_SRC:1]       active,
    input  logic [NUM_SRC:1][7:0]  ctrl,
    output logic                   present,
    output logic [SRC_IDX_W-1:0]   win_idx
);

    logic [NUM_SRC:1][4:0] cand_prio;

    generate
        for (genvar g = 1; g <= NUM_SRC; g++) begin : g_cand
            assign cand_prio[g] = active[g] ? ctrl[g][4:0] : 5'd0;
        end
    endgenerate

    logic [4:0] best;

    // Strictly-greater replacement: the lower index keeps a tie.
    always_comb begin
        best    = 5'd0;
        win_idx = '0;
        for (int n = 1; n <= int'(NUM_SRC); n++) begin
            if (cand_prio[n] > best) begin
                best    = cand_prio[n];
                win_idx = SRC_IDX_W'(n);
            end
        end
        present = (best >= PRESENT_FLOOR);
    end

endmodule

// File: rtl/prio_vec_intc_vecsel.sv
module prio_vec_intc_vecsel
    import prio_vec_intc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 13,
    parameter int unsigned WDOG_SRC = 8,
    parameter int unsigned SERA_SRC = 12,
    parameter int unsigned SERB_SRC = 13
) (
    input  logic                   present,
    input  logic [SRC_IDX_W-1:0]   win_idx,
    input  logic [NUM_SRC:1][7:0]  ctrl,
    input  logic [7:0]             vec_wdog,
    input  logic [7:0]             vec_sera,
    input  logic [7:0]             vec_serb,
    output irq_out_t               nxt
);

    logic [7:0] win_ctrl;

    always_comb begin
        win_ctrl = 8'h00;
        for (int n = 1; n <= int'(NUM_SRC); n++) begin
            if (win_idx == SRC_IDX_W'(n)) win_ctrl = ctrl[n];
        end
    end

    always_comb begin
        nxt = '0;
        if (present) begin
            nxt.level = win_ctrl[4:2];
            if (win_ctrl[7]) begin
                nxt.vector = AUTOVEC_BASE + {5'b0, win_ctrl[4:2]};
            end else if (win_idx == SRC_IDX_W'(WDOG_SRC)) begin
                nxt.vector = vec_wdog;
            end else if (win_idx == SRC_IDX_W'(SERA_SRC)) begin
                nxt.vector = vec_sera;
            end else if (win_idx == SRC_IDX_W'(SERB_SRC)) begin
                nxt.vector = vec_serb;
            end else begin
                nxt.vector = FALLBACK_VEC;
            end
        end
    end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import prio_vec_intc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 13,
    parameter int unsigned WDOG_SRC = 8,
    parameter int unsigned SERA_SRC = 12,
    parameter int unsigned SERB_SRC = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_req,
    input  logic [7:0]            bus_addr,
    input  logic                  bus_wr_en,
    input  logic [15:0]           bus_wr_data,
    output logic [15:0]           bus_rd_data,
    output logic [2:0]            irq_level,
    output logic [7:0]            irq_vector
);

    logic [NUM_SRC:1][7:0] ctrl_regs;
    logic [NUM_SRC:1]      mask_bits;
    logic [NUM_SRC:1]      pend_bits;
    logic [NUM_SRC:1]      active_bits;
    logic [7:0]            vec_wdog, vec_sera, vec_serb;
    logic                  win_present;
    logic [SRC_IDX_W-1:0]  win_idx;
    irq_out_t              out_nxt, out_q;

    prio_vec_intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr_en),
        .addr       (bus_addr),
        .wr_data    (bus_wr_data),
        .src_req    (src_req),
        .rd_data    (bus_rd_data),
        .ctrl_q     (ctrl_regs),
        .mask_q     (mask_bits),
        .pend       (pend_bits),
        .vec_wdog_q (vec_wdog),
        .vec_sera_q (vec_sera),
        .vec_serb_q (vec_serb)
    );

    assign active_bits = pend_bits & ~mask_bits;

    prio_vec_intc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .active  (active_bits),
        .ctrl    (ctrl_regs),
        .present (win_present),
        .win_idx (win_idx)
    );

    prio_vec_intc_vecsel #(
        .NUM_SRC  (NUM_SRC),
        .WDOG_SRC (WDOG_SRC),
        .SERA_SRC (SERA_SRC),
        .SERB_SRC (SERB_SRC)
    ) u_vecsel (
        .present  (win_present),
        .win_idx  (win_idx),
        .ctrl     (ctrl_regs),
        .vec_wdog (vec_wdog),
        .vec_sera (vec_sera),
        .vec_serb (vec_serb),
        .nxt      (out_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_nxt;
    end

    assign irq_level  = out_q.level;
    assign irq_vector = out_q.vector;

endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk
    import prio_vec_intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_req,
    input logic [NUM_SRC:1]   mask_bits,
    input logic [7:0]         bus_addr,
    input logic               bus_wr_en,
    input logic [15:0]        bus_wr_data,
    input logic [15:0]        bus_rd_data,
    input logic [2:0]         irq_level,
    input logic [7:0]         irq_vector
);

    localparam logic [15:0] MASK_KEEP = 16'(((1 << NUM_SRC) - 1) << 1);

    logic [1:0]         age;
    logic [NUM_SRC-1:0] live;
    logic [15:0]        pend_view;

    assign live      = src_req & ~mask_bits;
    assign pend_view = 16'({src_req, 1'b0});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_idle_vector_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd0) |-> (irq_vector == 8'h00));

    p_no_active_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $past(live) == '0) |-> (irq_level == 3'd0));

    p_level_needs_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && irq_level != 3'd0) |-> ($past(live) != '0));

    p_pend_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PEND) |-> (bus_rd_data == pend_view));

    p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $past(bus_wr_en) && $past(bus_addr) == A_MASK
         && bus_addr == A_MASK)
        |-> (bus_rd_data == ($past(bus_wr_data) & MASK_KEEP)));

endmodule

bind prio_vec_intc prio_vec_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req     (src_req),
    .mask_bits   (mask_bits),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_data (bus_rd_data),
    .irq_level   (irq_level),
    .irq_vector  (irq_vector)
);

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_req = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] bus_wr_data = '0;
    logic [15:0] bus_rd_data;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    int m_ctrl [1:13];
    int m_mask, m_wv, m_ua, m_ub;

    always #4 clk = ~clk;

    prio_vec_intc u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic model_reset();
        int init_ctrl [1:13] = '{4, 8, 12, 16, 20, 24, 28, 28, 128, 128, 128, 0, 0};
        for (int n = 1; n <= 13; n++) m_ctrl[n] = init_ctrl[n];
        m_mask = 'h3FFE; m_wv = 'h0F; m_ua = 'h0F; m_ub = 'h0F;
    endtask

    // descending scan, replace on >=: last replacement is the lowest index
    task automatic ref_eval(input int src, output int lvl, output int vec);
        int best = -1;
        int w = 0;
        for (int n = 13; n >= 1; n--) begin
            if (((src >> (n - 1)) & 1) == 1 && ((m_mask >> n) & 1) == 0) begin
                if ((m_ctrl[n] & 31) >= best) begin
                    best = m_ctrl[n] & 31;
                    w = n;
                end
            end
        end
        lvl = 0; vec = 0;
        if (best >= 4) begin
            lvl = (m_ctrl[w] >> 2) & 7;
            if ((m_ctrl[w] & 128) != 0) vec = 24 + lvl;
            else if (w == 8)  vec = m_wv;
            else if (w == 12) vec = m_ua;
            else if (w == 13) vec = m_ub;
            else vec = 'h0F;
        end
    endtask

    function automatic int exp_rd(input int a);
        if (a >= 'h14 && a <= 'h20) return m_ctrl[a - 'h13];
        case (a)
            'h36: return m_mask;
            'h3A: return (int'(src_req) << 1) & 'h3FFE;
            'h42: return m_wv;
            'h70: return m_ua;
            'h71: return m_ub;
            default: return 0;
        endcase
    endfunction

    task automatic model_write(input int a, input int d);
        if (a >= 'h14 && a <= 'h20) m_ctrl[a - 'h13] = d & 'hFF;
        else if (a == 'h36) m_mask = d & 'h3FFE;
        else if (a == 'h42) m_wv = d & 'hFF;
        else if (a == 'h70) m_ua = d & 'hFF;
        else if (a == 'h71) m_ub = d & 'hFF;
    endtask

    task automatic tick(input string tag);
        int el, ev;
        ref_eval(int'(src_req), el, ev);
        @(posedge clk);
        if (bus_wr_en) model_write(int'(bus_addr), int'(bus_wr_data));
        @(negedge clk);
        checks++;
        if (int'(irq_level) != el || int'(irq_vector) != ev) begin
            fails++;
            $display("FAIL %s: level/vector actual=%0d/0x%02h expected=%0d/0x%02h",
                     tag, irq_level, irq_vector, el, ev);
        end
    endtask

    task automatic wr(input int a, input int d, input string tag);
        bus_addr = 8'(a); bus_wr_data = 16'(d); bus_wr_en = 1'b1;
        tick(tag);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        int e;
        bus_addr = 8'(a);
        #1;
        e = exp_rd(a);
        checks++;
        if (int'(bus_rd_data) != e) begin
            fails++;
            $display("FAIL %s: read 0x%02h actual=0x%04h expected=0x%04h",
                     tag, a, bus_rd_data, e);
        end
    endtask

    task automatic set_src(input int v, input string tag);
        src_req = 13'(v);
        tick(tag);
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        checks++;
        if (irq_level != 0 || irq_vector != 0) begin
            fails++;
            $display("FAIL R1: outputs actual=%0d/%0d expected=0/0", irq_level, irq_vector);
        end
        for (int a = 'h14; a <= 'h20; a++) rd_chk(a, "R1");
        rd_chk('h36, "R1"); rd_chk('h42, "R1"); rd_chk('h70, "R1"); rd_chk('h71, "R1");

        // R2 pending view, write ignored; all masked gives nothing (R3)
        set_src('h1555, "R3");
        rd_chk('h3A, "R2");
        wr('h3A, 'hFFFF, "R2");
        rd_chk('h3A, "R2");
        rd_chk('h36, "R2");
        set_src('h1FFF, "R3");

        // R3 mask bits kept only 13:1
        wr('h36, 'hFFFF, "R3");
        rd_chk('h36, "R3");
        wr('h36, 'h3F7E, "R3");     // only source 7 unmasked
        tick("R9 R7");              // 0x1C -> level 7, fallback 0x0F
        wr('h36, 'h3E7E, "R5");     // 7 and 8 tie at 0x1C
        tick("R5");
        wr('h36, 'h3EFE, "R9");     // only source 8
        tick("R9");
        wr('h42, 'h55, "R9");
        tick("R9");
        rd_chk('h42, "R10");

        // R8 autovector, tie 3 vs 5 at code 0x14
        wr('h16, 'h94, "R8");
        rd_chk('h16, "R10");
        wr('h36, 'h3FD6, "R8");
        tick("R8 R5");
        wr('h36, 'h3FDE, "R9");     // only 5, no bit 7
        tick("R9");

        // R4 highest code, serial vectors
        wr('h1F, 'h1F, "R4");
        wr('h70, 'h40, "R9");
        wr('h36, 'h2FDE, "R4");     // 5 and 12
        tick("R4");
        wr('h20, 'h1E, "R4");
        wr('h71, 'h41, "R9");
        wr('h36, 'h1FDE, "R4");     // 5 and 13
        tick("R4");

        // R11 latency: drop and raise the winner
        set_src('h0FFF, "R11");
        set_src('h1FFF, "R11");

        // R6 sub-threshold code
        wr('h15, 'h03, "R6");
        wr('h36, 'h3FFA, "R6");     // only source 2
        tick("R6");
        wr('h15, 'h83, "R6");
        tick("R6");
        set_src('h0000, "R6");

        // R10 unmapped
        rd_chk('h00, "R10"); rd_chk('h50, "R10"); rd_chk('h21, "R10"); rd_chk('h13, "R10");

        // randomized mix
        for (int i = 0; i < 600; i++) begin
            src_req = 13'($urandom);
            if ((i % 4) == 0) begin
                int sel = $urandom % 16;
                if (sel < 13)       wr('h14 + sel, $urandom & 'hFF, "R4");
                else if (sel == 13) wr('h36, $urandom, "R4");
                else if (sel == 14) wr('h42 + ($urandom % 2) * 'h2E, $urandom & 'hFF, "R9");
                else                wr('h71, $urandom & 'hFF, "R9");
            end else begin
                tick("R4 R11");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule